// File: doc/BRIEF.md
# Bidirectional FIFO Host Port Controller

This block is the host-side access logic of a bidirectional FIFO. A processor-style port with a chip select, two address lines, a read/write line and a data strobe reaches six resources. These are a host-to-far-side queue, a far-side-to-host queue, a one-way bypass bus, a command register, a status register and eight configuration registers. All of them share one 18-bit data bus. Queue words use all 18 bits. Register words use the low 16 bits. Bypass bytes are 9 bits wide, taken from bits 7..0 plus bit 16.

An access happens once per strobe, on the clock edge where the strobe is first seen active with chip select high. Read data is registered at that edge and is driven onto the bus from the following cycle for as long as the read strobe stays active. The far side has its own pop and push controls on the two queues. These run independently of the host port. The bypass path only operates while peripheral mode is selected, which is bit 10 of configuration register 5.

Top module: `bfifo_host_port`

## Requirements
- R1: An access fires once per strobe assertion, on the first rising clock edge where `host_cs` and `host_strobe` are both 1. Holding the strobe does not repeat the access. Read data appears on `host_dout` from the next cycle.
- R2: `host_addr`=00 selects the queues. A write pushes all 18 bits into the host-to-far queue, which the far side sees in order on `b_ab_data`. A read pops the far-to-host queue and returns all 18 bits in push order.
- R3: A write to a full queue is dropped. A read from an empty queue leaves the returned read data equal to the previous read value.
- R4: Register accesses (`host_addr`=10 or 11) store only bits 15..0 of the write data, and the read data has bits 17..16 at 0.
- R5: `host_addr`=10 writes and reads back the command register. Bits 2..0 of the command register are the configuration pointer, and bit 3 is the view select.
- R6: A write with `host_addr`=11 stores into the configuration register chosen by the pointer. A read with `host_addr`=11 returns the status word when the view bit is 0, and the pointed configuration register when it is 1. The status word holds host-to-far empty in bit 0, host-to-far full in bit 1, far-to-host empty in bit 2, far-to-host full in bit 3, peripheral mode in bit 4, and 0 in all other bits.
- R7: While peripheral mode is on, a bypass write (`host_addr`=01) latches {bit 16, bits 7..0} onto `b_byp_data` and sets `b_byp_oe`. `b_strobe_oe` equals peripheral mode. A bypass read returns 0.
- R8: While peripheral mode is off, `b_byp_oe` is 0, `b_byp_data` is 0, and a bypass write is ignored; it does not change the latched byte.
- R9: `host_doe` is 1 only while `host_cs`, `host_strobe` and `host_rd` are all 1, and `host_dout` is 0 whenever `host_doe` is 0.
- R10: A far-side pop or push in the same cycle as a host access to the same queue takes effect along with the host access. Fullness and emptiness are judged on the queue state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select, active high |
| host_addr | input | 2 | Resource select |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_strobe | input | 1 | Data strobe, active high |
| host_din | input | 18 | Host write data |
| host_dout | output | 18 | Host read data |
| host_doe | output | 1 | Host data output enable |
| b_ab_pop | input | 1 | Far side pops host-to-far queue |
| b_ab_data | output | 18 | Head of host-to-far queue |
| b_ab_empty | output | 1 | Host-to-far queue empty |
| b_ba_push | input | 1 | Far side pushes far-to-host queue |
| b_ba_din | input | 18 | Far-side push data |
| b_ba_full | output | 1 | Far-to-host queue full |
| b_byp_data | output | 9 | Bypass byte toward far side |
| b_byp_oe | output | 1 | Bypass byte output enable |
| b_strobe_oe | output | 1 | Far-side strobe pins driven as outputs |

## Verification
The risky overlap is a host queue access landing on the same clock edge as a far-side pop or push of that queue. The bench lines these up by asserting `b_ab_pop` or `b_ba_push` in the exact cycle the host strobe fires. It does this once on a partly filled queue and once on a full one. The outcome is judged afterwards by draining the queue from the far side and comparing the word sequence with the expected order. In the full case the host word must be missing while the popped word is gone.

// File: rtl/bfh_pkg.sv
package bfh_pkg;
    parameter int unsigned WORD_W     = 18;
    parameter int unsigned REG_W      = 16;
    parameter int unsigned BYP_W      = 9;
    parameter int unsigned CFG_N      = 8;
    parameter int unsigned PTR_W      = $clog2(CFG_N);
    parameter int unsigned PERIPH_REG = 5;
    parameter int unsigned PERIPH_BIT = 10;

    typedef enum logic [1:0] {
        RES_QUEUE = 2'b00,
        RES_BYP   = 2'b01,
        RES_CMD   = 2'b10,
        RES_CFG   = 2'b11
    } res_e;

    typedef struct packed {
        logic wr;
        logic rd;
        res_e res;
    } acc_t;

    typedef struct packed {
        logic periph;
        logic ba_full;
        logic ba_empty;
        logic ab_full;
        logic ab_empty;
    } stat_t;

    function automatic logic [BYP_W-1:0] byp_pick(input logic [WORD_W-1:0] w);
        return {w[16], w[7:0]};
    endfunction

    function automatic logic [WORD_W-1:0] reg_widen(input logic [REG_W-1:0] r);
        return {{(WORD_W-REG_W){1'b0}}, r};
    endfunction

    function automatic logic [REG_W-1:0] status_word(input stat_t s);
        logic [REG_W-1:0] v;
        v    = '0;
        v[0] = s.ab_empty;
        v[1] = s.ab_full;
        v[2] = s.ba_empty;
        v[3] = s.ba_full;
        v[4] = s.periph;
        return v;
    endfunction
endpackage

// File: rtl/bfh_decode.sv
module bfh_decode
    import bfh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       strobe,
    input  logic       rd,
    input  logic [1:0] addr,
    output acc_t       acc
);
    logic strobe_q;
    logic fire;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign fire = cs & strobe & ~strobe_q;

    always_comb begin
        acc.wr  = fire & ~rd;
        acc.rd  = fire & rd;
        acc.res = res_e'(addr);
    end
endmodule

// File: rtl/bfh_fifo.sv
module bfh_fifo #(
    parameter int unsigned W     = 18,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/bfh_regs.sv
module bfh_regs
    import bfh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic             wr_cfg,
    input  logic [REG_W-1:0] din,
    output logic [REG_W-1:0] cmd,
    output logic [REG_W-1:0] cfg_sel,
    output logic             view_cfg,
    output logic             periph
);
    logic [REG_W-1:0] cfg [CFG_N];
    logic [PTR_W-1:0] ptr;

    assign ptr      = cmd[PTR_W-1:0];
    assign view_cfg = cmd[PTR_W];
    assign cfg_sel  = cfg[ptr];
    assign periph   = cfg[PERIPH_REG][PERIPH_BIT];

    always_ff @(posedge clk) begin
        if (rst) cmd <= '0;
        else if (wr_cmd) cmd <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_N; i++) cfg[i] <= '0;
        end else if (wr_cfg) begin
            for (int i = 0; i < CFG_N; i++) begin
                if (ptr == PTR_W'(i)) cfg[i] <= din;
            end
        end
    end
endmodule

// File: rtl/bfifo_host_port.sv
module bfifo_host_port
    import bfh_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic [1:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_strobe,
    input  logic [WORD_W-1:0] host_din,
    output logic [WORD_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              b_ab_pop,
    output logic [WORD_W-1:0] b_ab_data,
    output logic              b_ab_empty,
    input  logic              b_ba_push,
    input  logic [WORD_W-1:0] b_ba_din,
    output logic              b_ba_full,
    output logic [BYP_W-1:0]  b_byp_data,
    output logic              b_byp_oe,
    output logic              b_strobe_oe
);
    acc_t              acc;
    logic              ab_full, ab_empty, ba_full, ba_empty;
    logic [WORD_W-1:0] ba_head;
    logic [REG_W-1:0]  cmd, cfg_sel;
    logic              view_cfg, periph;
    logic [WORD_W-1:0] rd_q;
    logic [BYP_W-1:0]  byp_q;
    logic              byp_valid;
    stat_t             stat;

    bfh_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .cs     (host_cs),
        .strobe (host_strobe),
        .rd     (host_rd),
        .addr   (host_addr),
        .acc    (acc)
    );

    bfh_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .push  (acc.wr && acc.res == RES_QUEUE),
        .din   (host_din),
        .pop   (b_ab_pop),
        .dout  (b_ab_data),
        .empty (ab_empty),
        .full  (ab_full)
    );

    bfh_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .push  (b_ba_push),
        .din   (b_ba_din),
        .pop   (acc.rd && acc.res == RES_QUEUE),
        .dout  (ba_head),
        .empty (ba_empty),
        .full  (ba_full)
    );

    bfh_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (acc.wr && acc.res == RES_CMD),
        .wr_cfg   (acc.wr && acc.res == RES_CFG),
        .din      (host_din[REG_W-1:0]),
        .cmd      (cmd),
        .cfg_sel  (cfg_sel),
        .view_cfg (view_cfg),
        .periph   (periph)
    );

    always_comb begin
        stat.ab_empty = ab_empty;
        stat.ab_full  = ab_full;
        stat.ba_empty = ba_empty;
        stat.ba_full  = ba_full;
        stat.periph   = periph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (acc.rd) begin
            case (acc.res)
                RES_QUEUE: if (!ba_empty) rd_q <= ba_head;
                RES_BYP:   rd_q <= '0;
                RES_CMD:   rd_q <= reg_widen(cmd);
                default:   rd_q <= reg_widen(view_cfg ? cfg_sel : status_word(stat));
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q     <= '0;
            byp_valid <= 1'b0;
        end else if (acc.wr && acc.res == RES_BYP && periph) begin
            byp_q     <= byp_pick(host_din);
            byp_valid <= 1'b1;
        end
    end

    assign host_doe    = host_cs & host_strobe & host_rd;
    assign host_dout   = host_doe ? rd_q : '0;
    assign b_ab_empty  = ab_empty;
    assign b_ba_full   = ba_full;
    assign b_byp_oe    = periph & byp_valid;
    assign b_byp_data  = b_byp_oe ? byp_q : '0;
    assign b_strobe_oe = periph;
endmodule

// File: rtl/bfh_checker.sv
module bfh_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_cs,
    input logic [1:0]  host_addr,
    input logic        host_rd,
    input logic        host_strobe,
    input logic [17:0] host_din,
    input logic [17:0] host_dout,
    input logic        b_ab_pop,
    input logic [17:0] b_ab_data,
    input logic        b_ba_push,
    input logic [8:0]  b_byp_data,
    input logic        b_byp_oe,
    input logic        periph,
    input logic        ab_full,
    input logic        ba_empty
);
    logic stb_seen;
    logic go;

    always_ff @(posedge clk) begin
        if (rst) stb_seen <= 1'b0;
        else     stb_seen <= host_strobe;
    end

    assign go = host_cs & host_strobe & ~stb_seen;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (go && !host_rd && host_addr == 2'b00 && ab_full && !b_ab_pop)
        |=> (ab_full && $stable(b_ab_data)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (go && host_rd && host_addr == 2'b00 && ba_empty && !b_ba_push)
        |=> ba_empty);

    p_reg_width_r4: assert property (@(posedge clk) disable iff (rst)
        (go && host_rd && host_addr[1])
        |=> (host_dout[17:16] == 2'b00));

    p_byp_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (go && !host_rd && host_addr == 2'b01 && periph)
        |=> (b_byp_oe && b_byp_data == {$past(host_din[16]), $past(host_din[7:0])}));

    p_byp_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !periph |-> (!b_byp_oe && b_byp_data == 9'd0));
endmodule

bind bfifo_host_port bfh_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_cs     (host_cs),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_strobe (host_strobe),
    .host_din    (host_din),
    .host_dout   (host_dout),
    .b_ab_pop    (b_ab_pop),
    .b_ab_data   (b_ab_data),
    .b_ba_push   (b_ba_push),
    .b_byp_data  (b_byp_data),
    .b_byp_oe    (b_byp_oe),
    .periph      (periph),
    .ab_full     (ab_full),
    .ba_empty    (ba_empty)
);

// File: tb/sim_bfifo_host_port.sv
module sim_bfifo_host_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs = 1'b0;
    logic [1:0]  host_addr = 2'b00;
    logic        host_rd = 1'b0;
    logic        host_strobe = 1'b0;
    logic [17:0] host_din = '0;
    logic [17:0] host_dout;
    logic        host_doe;
    logic        b_ab_pop = 1'b0;
    logic [17:0] b_ab_data;
    logic        b_ab_empty;
    logic        b_ba_push = 1'b0;
    logic [17:0] b_ba_din = '0;
    logic        b_ba_full;
    logic [8:0]  b_byp_data;
    logic        b_byp_oe;
    logic        b_strobe_oe;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [17:0] got;
    logic        got_oe;

    always #10 clk = ~clk;

    bfifo_host_port #(.DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_addr(host_addr),
        .host_rd(host_rd), .host_strobe(host_strobe), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .b_ab_pop(b_ab_pop),
        .b_ab_data(b_ab_data), .b_ab_empty(b_ab_empty), .b_ba_push(b_ba_push),
        .b_ba_din(b_ba_din), .b_ba_full(b_ba_full), .b_byp_data(b_byp_data),
        .b_byp_oe(b_byp_oe), .b_strobe_oe(b_strobe_oe)
    );

    task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one strobe; optional far-side pop/push in the firing cycle
    task automatic access(input logic [1:0] a, input logic rd, input logic [17:0] d,
                          input logic pop, input logic push, input logic [17:0] pd);
        host_cs = 1'b1; host_addr = a; host_rd = rd; host_din = d; host_strobe = 1'b1;
        b_ab_pop = pop; b_ba_push = push; b_ba_din = pd;
        @(negedge clk);
        got = host_dout; got_oe = host_doe;
        b_ab_pop = 1'b0; b_ba_push = 1'b0;
        host_strobe = 1'b0; host_cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [17:0] d);
        access(a, 1'b0, d, 1'b0, 1'b0, '0);
    endtask

    task automatic rd(input logic [1:0] a);
        access(a, 1'b1, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic far_pop(input logic [17:0] exp, input string tag);
        check({17'd0, b_ab_empty}, 18'd0, tag);
        check(b_ab_data, exp, tag);
        b_ab_pop = 1'b1;
        @(negedge clk);
        b_ab_pop = 1'b0;
    endtask

    task automatic far_push(input logic [17:0] d);
        b_ba_push = 1'b1; b_ba_din = d;
        @(negedge clk);
        b_ba_push = 1'b0;
    endtask

    task automatic set_periph(input logic on);
        wr(2'b10, 18'h00005);
        wr(2'b11, on ? 18'h00400 : 18'h00000);
    endtask

    task automatic t_reset;
        check({17'd0, host_doe}, 18'd0, "R9 reset doe");
        check({17'd0, b_ab_empty}, 18'd1, "R2 reset ab empty");
        check({17'd0, b_byp_oe}, 18'd0, "R8 reset byp oe");
        check({17'd0, b_strobe_oe}, 18'd0, "R7 reset strobe oe");
        rd(2'b11);
        check(got, 18'h00005, "R6 reset status");
    endtask

    task automatic t_doe;
        host_cs = 1'b1; host_strobe = 1'b1; host_rd = 1'b0; host_addr = 2'b10;
        #1 check({17'd0, host_doe}, 18'd0, "R9 write no doe");
        host_cs = 1'b0; host_rd = 1'b1;
        #1 check({17'd0, host_doe}, 18'd0, "R9 no cs no doe");
        check(host_dout, 18'd0, "R9 dout zero");
        host_cs = 1'b1; host_strobe = 1'b0;
        #1 check({17'd0, host_doe}, 18'd0, "R9 no strobe no doe");
        host_cs = 1'b0;
        @(negedge clk);
        rd(2'b10);
        check({17'd0, got_oe}, 18'd1, "R9 read doe");
        // held strobe pushes once
        host_cs = 1'b1; host_addr = 2'b00; host_rd = 1'b0; host_din = 18'h2_1111; host_strobe = 1'b1;
        repeat (3) @(negedge clk);
        host_strobe = 1'b0; host_cs = 1'b0;
        @(negedge clk);
        far_pop(18'h2_1111, "R1 held strobe");
        check({17'd0, b_ab_empty}, 18'd1, "R1 single push");
    endtask

    task automatic t_queue;
        wr(2'b00, 18'h2_AAAA);
        wr(2'b00, 18'h1_5555);
        wr(2'b00, 18'h3_0F0F);
        far_pop(18'h2_AAAA, "R2 order0");
        far_pop(18'h1_5555, "R2 order1");
        far_pop(18'h3_0F0F, "R2 order2");
        far_push(18'h3_1234);
        far_push(18'h2_8001);
        rd(2'b00);
        check(got, 18'h3_1234, "R2 host read0");
        rd(2'b00);
        check(got, 18'h2_8001, "R2 host read1");
    endtask

    task automatic t_limits;
        for (int i = 0; i < 5; i++) wr(2'b00, 18'(18'h1_0000 + i));
        rd(2'b11);
        check(got, 18'h00006, "R6 full status");
        for (int i = 0; i < 4; i++) far_pop(18'(18'h1_0000 + i), "R3 kept word");
        check({17'd0, b_ab_empty}, 18'd1, "R3 fifth dropped");
        far_push(18'h2_BEEF);
        rd(2'b00);
        check(got, 18'h2_BEEF, "R3 last word");
        rd(2'b00);
        check(got, 18'h2_BEEF, "R3 empty read holds");
    endtask

    task automatic t_regs;
        wr(2'b10, 18'h3_A5F0);
        rd(2'b10);
        check(got, 18'h0_A5F0, "R4 R5 cmd readback");
        wr(2'b10, 18'h0000C);
        wr(2'b11, 18'h3_0400);
        rd(2'b11);
        check(got, 18'h0_0400, "R4 R6 cfg4 view");
        wr(2'b10, 18'h00004);
        rd(2'b11);
        check(got, 18'h00005, "R6 cfg4 not periph");
        set_periph(1'b1);
        rd(2'b11);
        check(got, 18'h00015, "R6 periph status");
        check({17'd0, b_strobe_oe}, 18'd1, "R7 strobe oe");
    endtask

    task automatic t_bypass;
        set_periph(1'b0);
        wr(2'b01, 18'h0_0055);
        check({17'd0, b_byp_oe}, 18'd0, "R8 off write no oe");
        set_periph(1'b1);
        check({17'd0, b_byp_oe}, 18'd0, "R8 ignored write stays");
        wr(2'b01, 18'h3_5A7E);
        check({17'd0, b_byp_oe}, 18'd1, "R7 byp oe");
        check({9'd0, b_byp_data}, 18'h0017E, "R7 byp byte");
        rd(2'b01);
        check(got, 18'd0, "R7 byp read zero");
        set_periph(1'b0);
        check({17'd0, b_byp_oe}, 18'd0, "R8 oe drops");
        check({9'd0, b_byp_data}, 18'd0, "R8 data zero");
        wr(2'b01, 18'h0_0011);
        set_periph(1'b1);
        check({9'd0, b_byp_data}, 18'h0017E, "R8 byte unchanged");
    endtask

    task automatic t_overlap;
        wr(2'b00, 18'h0_0A00);
        wr(2'b00, 18'h0_0A01);
        wr(2'b00, 18'h0_0A02);
        access(2'b00, 1'b0, 18'h0_0A03, 1'b1, 1'b0, '0);
        wr(2'b00, 18'h0_0A04);
        access(2'b00, 1'b0, 18'h0_0A05, 1'b1, 1'b0, '0);
        far_pop(18'h0_0A02, "R10 after overlap0");
        far_pop(18'h0_0A03, "R10 after overlap1");
        far_pop(18'h0_0A04, "R10 full push dropped");
        check({17'd0, b_ab_empty}, 18'd1, "R10 drained");
        far_push(18'h1_0C00);
        access(2'b00, 1'b1, '0, 1'b0, 1'b1, 18'h1_0C01);
        check(got, 18'h1_0C00, "R10 read with push");
        rd(2'b00);
        check(got, 18'h1_0C01, "R10 pushed kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_doe();
        t_queue();
        t_limits();
        t_regs();
        t_bypass();
        t_overlap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule